// File: doc/BRIEF.md
# Pause Quanta Countdown Timer

This block holds the remaining pause time for full-duplex flow control and keeps the transmitter from starting new frames while a pause is in force. A pause frame detector hands it a one-cycle load pulse together with the requested pause time. The transmit state machine reads back a transmit-inhibit level. It reports a stopped indication once the line is idle. All inputs are already synchronous to the block's clock. The receive-clock cadence arrives as a one-cycle tick enable.

The timer counts down in quanta of 512 bit times, which is 128 ticks in nibble mode. When the pause-enable bit is set, the countdown advances only while transmission is stopped. When that bit is clear, the countdown advances whether or not transmission is stopped. A test mode removes the prescaler so that every qualifying tick takes one count off. Two masked, one-cycle interrupts report the arrival of a pause frame and the expiry of the pause time.

Top module: `pause_quanta_timer`

## Requirements
- R1: A load pulse while `full_duplex` is 1 overwrites the pause time with `pause_value` at the next clock edge, whatever the old contents and whatever `pause_en` holds.
- R2: A load pulse while `full_duplex` is 0 leaves the pause time unchanged.
- R3: Every load pulse, in either duplex mode, makes `irq_pause_rx` 1 for exactly the following cycle when `mask_rx` is 1, and leaves it at 0 when `mask_rx` is 0.
- R4: `tx_inhibit` is 1 exactly when `pause_en` is 1 and the pause time is nonzero. While `pause_en` is 1 and `tx_stopped` is 0, the pause time does not change.
- R5: With `retry_test` at 0, the pause time drops by one on every `QUANTUM_CYC`-th qualifying tick (default 128). A qualifying tick is a cycle with `tick` at 1, a nonzero pause time and no load. When `pause_en` is 1, `tx_stopped` must also be 1.
- R6: With `retry_test` at 1, every qualifying tick lowers the pause time by one.
- R7: With `pause_en` at 0, the countdown advances on ticks regardless of `tx_stopped`.
- R8: When a decrement takes the pause time from 1 to 0, `irq_pause_exp` is 1 for exactly one cycle after that edge, provided `mask_exp` is 1. The pulse appears in the same cycle in which `tx_inhibit` falls.
- R9: The pause time stops at zero and never wraps. Further ticks raise no further expiry interrupt.
- R10: Each load restarts the quantum prescaler, so the first quantum after a load is a full `QUANTUM_CYC` ticks.
- R11: A full-duplex load of zero clears the pause time at once and raises no expiry interrupt.
- R12: A load takes priority over a decrement in the same cycle. The new value is taken as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pause_load | input | 1 | One-cycle pulse: a valid pause frame was received |
| pause_value | input | TIME_W | Pause time carried by that frame, in quanta |
| full_duplex | input | 1 | 1 = full-duplex operation |
| pause_en | input | 1 | 1 = received pauses gate transmission |
| retry_test | input | 1 | 1 = bypass prescaler, one count per tick |
| tick | input | 1 | One-cycle receive-clock cadence enable |
| tx_stopped | input | 1 | 1 = transmitter idle |
| mask_rx | input | 1 | Enable for the pause-received interrupt |
| mask_exp | input | 1 | Enable for the pause-expired interrupt |
| tx_inhibit | output | 1 | 1 = do not start a new frame |
| irq_pause_rx | output | 1 | Pause-received interrupt pulse |
| irq_pause_exp | output | 1 | Pause-expired interrupt pulse |

## Verification
A load driven in one cycle changes the pause time at the next edge. Both `tx_inhibit` and `irq_pause_rx` show the result in the cycle that follows that edge. Each decrement is visible one cycle after the tick that causes it, and the expiry pulse appears in that same cycle while the inhibit falls. The bench therefore applies every stimulus at a falling edge and samples at the next falling edge. It counts the expiry pulses seen at each of those samples during a tick run, then compares the count with the number of quanta computed from the run length.

// File: rtl/pqt_pkg.sv
package pqt_pkg;

   typedef enum logic [0:0] {
      STEP_QUANTUM = 1'b0,
      STEP_EVERY   = 1'b1
   } pqt_step_e;

   function automatic int unsigned pqt_pre_w(input int unsigned cyc);
      return (cyc <= 2) ? 1 : $clog2(cyc);
   endfunction

endpackage

// File: rtl/pqt_prescaler.sv
module pqt_prescaler
   import pqt_pkg::*;
#(
   parameter int unsigned QUANTUM_CYC = 128
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      restart,
   input  logic      advance,
   input  pqt_step_e mode,
   output logic      quantum
);
   localparam int unsigned PW = pqt_pre_w(QUANTUM_CYC);
   localparam logic [PW-1:0] LAST = PW'(QUANTUM_CYC - 1);

   generate
      if (QUANTUM_CYC == 1) begin : g_direct
         assign quantum = advance;
      end else begin : g_count
         logic [PW-1:0] pre_q;
         logic          wrap;

         assign wrap    = (mode == STEP_EVERY) || (pre_q == LAST);
         assign quantum = advance && wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (restart) begin
               pre_q <= '0;
            end else if (advance) begin
               pre_q <= wrap ? '0 : pre_q + 1'b1;
            end
         end

         AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST) else $error("prescaler out of range"); // R5
         AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> pre_q == '0) else $error("prescaler not restarted"); // R10
      end
   endgenerate

endmodule

// File: rtl/pqt_counter.sv
module pqt_counter #(
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic              step,
   output logic [TIME_W-1:0] count,
   output logic              nonzero,
   output logic              hits_zero
);
   logic [TIME_W-1:0] cnt_q;

   assign count     = cnt_q;
   assign nonzero   = |cnt_q;
   assign hits_zero = step && !load && (cnt_q == TIME_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step && nonzero) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val)) else $error("load lost"); // R1
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) && !load |=> cnt_q == '0) else $error("wrapped"); // R9
   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt_q == $past(cnt_q)) || (cnt_q == TIME_W'($past(cnt_q) - 1'b1)))
      else $error("step larger than one"); // R5

endmodule

// File: rtl/pqt_irq.sv
module pqt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_seen,
   input  logic expired,
   input  logic mask_rx,
   input  logic mask_exp,
   output logic irq_rx,
   output logic irq_exp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_rx  <= 1'b0;
         irq_exp <= 1'b0;
      end else begin
         irq_rx  <= frame_seen && mask_rx;
         irq_exp <= expired && mask_exp;
      end
   end

   AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_rx |=> !irq_rx) else $error("rx irq through mask"); // R3
   AST_EXP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_exp |=> !irq_exp) else $error("exp irq through mask"); // R8

endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer
   import pqt_pkg::*;
#(
   parameter int unsigned TIME_W      = 16,
   parameter int unsigned QUANTUM_CYC = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pause_load,
   input  logic [TIME_W-1:0] pause_value,
   input  logic              full_duplex,
   input  logic              pause_en,
   input  logic              retry_test,
   input  logic              tick,
   input  logic              tx_stopped,
   input  logic              mask_rx,
   input  logic              mask_exp,
   output logic              tx_inhibit,
   output logic              irq_pause_rx,
   output logic              irq_pause_exp
);
   generate
      if (TIME_W < 2) begin : g_bad_width
         $error("TIME_W must be at least 2");
      end
      if (QUANTUM_CYC < 1) begin : g_bad_quantum
         $error("QUANTUM_CYC must be at least 1");
      end
   endgenerate

   logic              load_fd;
   logic              may_run;
   logic              advance;
   logic              quantum;
   logic [TIME_W-1:0] count;
   logic              nonzero;
   logic              hits_zero;
   pqt_step_e         mode;

   assign load_fd = pause_load && full_duplex;
   assign may_run = pause_en ? tx_stopped : 1'b1;
   assign advance = tick && may_run && nonzero && !load_fd;
   assign mode    = retry_test ? STEP_EVERY : STEP_QUANTUM;

   pqt_prescaler #(.QUANTUM_CYC(QUANTUM_CYC)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load_fd),
      .advance (advance),
      .mode    (mode),
      .quantum (quantum)
   );

   pqt_counter #(.TIME_W(TIME_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_fd),
      .load_val  (pause_value),
      .step      (quantum),
      .count     (count),
      .nonzero   (nonzero),
      .hits_zero (hits_zero)
   );

   pqt_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_seen (pause_load),
      .expired    (hits_zero),
      .mask_rx    (mask_rx),
      .mask_exp   (mask_exp),
      .irq_rx     (irq_pause_rx),
      .irq_exp    (irq_pause_exp)
   );

   assign tx_inhibit = pause_en && nonzero;

   AST_HD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pause_load && !full_duplex && (count == '0) |=> count == '0)
      else $error("half duplex load"); // R2
   AST_HOLD_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
      pause_en && !tx_stopped && !load_fd |=> $stable(count))
      else $error("count moved while sending"); // R4
   AST_EXP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pause_exp |-> count == '0) else $error("expiry with time left"); // R8
   AST_ZERO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      load_fd && (pause_value == '0) |=> !irq_pause_exp)
      else $error("expiry on zero load"); // R11

endmodule

// File: tb/tb_pause_quanta_timer.sv
module tb_pause_quanta_timer;
   localparam int TW = 16;
   localparam int QC = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pause_load = 1'b0;
   logic [TW-1:0] pause_value = '0;
   logic full_duplex = 1'b1, pause_en = 1'b1, retry_test = 1'b0;
   logic tick = 1'b0, tx_stopped = 1'b1, mask_rx = 1'b1, mask_exp = 1'b1;
   logic tx_inhibit, irq_pause_rx, irq_pause_exp;

   int total = 0;
   int bad = 0;
   int exp_seen;
   logic done = 1'b0;

   always #4 clk = ~clk;

   pause_quanta_timer #(.TIME_W(TW), .QUANTUM_CYC(QC)) dut (
      .clk(clk), .rst_n(rst_n), .pause_load(pause_load), .pause_value(pause_value),
      .full_duplex(full_duplex), .pause_en(pause_en), .retry_test(retry_test),
      .tick(tick), .tx_stopped(tx_stopped), .mask_rx(mask_rx), .mask_exp(mask_exp),
      .tx_inhibit(tx_inhibit), .irq_pause_rx(irq_pause_rx), .irq_pause_exp(irq_pause_exp)
   );

   typedef struct packed {
      logic [15:0] val;
      logic        fd;
      logic        en;
      logic        rt;
      logic        st;
      logic [11:0] ncyc;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{16'd3, 1'b1, 1'b1, 1'b1, 1'b1, 12'd2},
      '{16'd3, 1'b1, 1'b1, 1'b1, 1'b1, 12'd3},
      '{16'd2, 1'b1, 1'b1, 1'b0, 1'b1, 12'd256},
      '{16'd2, 1'b1, 1'b1, 1'b0, 1'b1, 12'd255},
      '{16'd5, 1'b1, 1'b1, 1'b1, 1'b0, 12'd20},
      '{16'd4, 1'b1, 1'b0, 1'b1, 1'b0, 12'd4},
      '{16'd7, 1'b0, 1'b1, 1'b1, 1'b1, 12'd5},
      '{16'd9, 1'b1, 1'b0, 1'b1, 1'b0, 12'd3},
      '{16'd2, 1'b1, 1'b1, 1'b1, 1'b1, 12'd10}
   };

   task automatic chk(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic load(input logic [TW-1:0] v, input logic with_tick);
      @(negedge clk);
      pause_value = v;
      pause_load  = 1'b1;
      tick        = with_tick;
      @(negedge clk);
      pause_load  = 1'b0;
      tick        = 1'b0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         if (irq_pause_exp) exp_seen++;
      end
      tick = 1'b0;
   endtask

   task automatic clear_timer();
      full_duplex = 1'b1;
      load('0, 1'b0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset inhibit", tx_inhibit, 0);
      chk("R3 reset rx irq", irq_pause_rx, 0);
      chk("R8 reset exp irq", irq_pause_exp, 0);

      // vector table: R1 R2 R4 R5 R6 R7 R8 R9
      for (int k = 0; k < NV; k++) begin
         int loaded, q, rem, e_exp, e_inh;
         clear_timer();
         full_duplex = VECS[k].fd;
         pause_en    = VECS[k].en;
         retry_test  = VECS[k].rt;
         tx_stopped  = VECS[k].st;
         load(VECS[k].val, 1'b0);
         chk($sformatf("R3 vec%0d rx irq", k), irq_pause_rx, 1);
         loaded = VECS[k].fd ? int'(VECS[k].val) : 0;
         if (VECS[k].en && !VECS[k].st) q = 0;
         else q = VECS[k].rt ? int'(VECS[k].ncyc) : int'(VECS[k].ncyc) / QC;
         rem   = (q >= loaded) ? 0 : loaded - q;
         e_exp = (loaded != 0 && q >= loaded) ? 1 : 0;
         e_inh = (VECS[k].en && rem != 0) ? 1 : 0;
         exp_seen = 0;
         run_ticks(int'(VECS[k].ncyc));
         chk($sformatf("R5 R6 R7 R9 vec%0d expiry count", k), exp_seen, e_exp);
         chk($sformatf("R1 R2 R4 vec%0d inhibit", k), tx_inhibit, e_inh);
      end

      // R10: reload mid-quantum restarts the prescaler
      clear_timer();
      pause_en = 1'b1; retry_test = 1'b0; tx_stopped = 1'b1;
      load(16'd1, 1'b0);
      exp_seen = 0;
      run_ticks(100);
      load(16'd1, 1'b0);
      run_ticks(QC - 1);
      chk("R10 no expiry before full quantum", exp_seen, 0);
      chk("R10 still inhibited", tx_inhibit, 1);
      run_ticks(1);
      chk("R10 expiry after full quantum", exp_seen, 1);
      chk("R8 inhibit falls with expiry", tx_inhibit, 0);

      // R11: zero load clears without expiry
      retry_test = 1'b1;
      load(16'd5, 1'b0);
      run_ticks(2);
      chk("R11 inhibited before zero load", tx_inhibit, 1);
      exp_seen = 0;
      load('0, 1'b0);
      if (irq_pause_exp) exp_seen++;
      chk("R11 cleared at once", tx_inhibit, 0);
      run_ticks(5);
      chk("R11 no expiry", exp_seen, 0);

      // R12: load wins over a same-cycle decrement
      load(16'd1, 1'b0);
      load(16'd2, 1'b1);
      exp_seen = 0;
      run_ticks(1);
      chk("R12 loaded value kept", tx_inhibit, 1);
      chk("R12 no early expiry", exp_seen, 0);
      run_ticks(1);
      chk("R12 expiry after two steps", exp_seen, 1);

      // R3 R8: masks
      mask_rx = 1'b0; mask_exp = 1'b0;
      load(16'd1, 1'b0);
      chk("R3 masked rx irq", irq_pause_rx, 0);
      exp_seen = 0;
      run_ticks(3);
      chk("R8 masked expiry", exp_seen, 0);
      chk("R8 count still expired", tx_inhibit, 0);
      mask_rx = 1'b1;
      @(negedge clk);
      chk("R3 rx pulse one cycle", irq_pause_rx, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule